// File: doc/BRIEF.md
# Three-Level Privilege Mode Controller

This block holds the privilege level of one processor core and moves it between user, system and fault levels. It responds to three single-cycle request strobes: a supervisor call, an exception and an exception return. Fault is the terminal level. The core reaches it only through a double fault, which is an exception taken while already at system level. Once in fault, the controller does not return to a lower level. It raises a sticky halt request instead.

All outputs are registered. A transition shows up on the clock edge that samples the request: the new mode, a one-cycle change pulse, a vector select for the handler entry, and a save or restore pulse for the banked program-counter file. That register file is outside this block. The reset input is asserted asynchronously and released through a synchronizer.

Top module: `priv_mode_ctrl`

## Requirements
- R1: While reset is applied, and after it is released, the mode is system (2'b01). The change pulse, save pulse and restore pulse are 0, the vector select is 2'b00 and halt is 0.
- R2: A supervisor call in user mode (2'b00), with no exception, moves to system mode after the sampling edge. It pulses the change output and save_pc_o, and shows vector select 2'b01.
- R3: An exception in user mode moves to system mode. It pulses the change output and save_pc_o, and shows vector select 2'b10.
- R4: When a supervisor call and an exception arrive in the same cycle in user mode, the exception wins and the vector select is 2'b10.
- R5: An exception in system mode is a double fault. It moves to fault mode (2'b10), pulses the change output and save_pc_o, and shows vector select 2'b11.
- R6: An exception return in system mode, with no exception, moves to user mode. It pulses the change output and restore_pc_o, with vector select 2'b00.
- R7: When an exception and an exception return arrive in the same cycle in system mode, the exception wins and the core enters fault mode.
- R8: An exception return in user mode and a supervisor call in system mode have no effect: the mode holds and no pulse is produced.
- R9: In fault mode every request is ignored and the mode holds. Any request sets halt_o, which then stays at 1 until reset.
- R10: The change pulse is 1 in exactly the cycles where the mode differs from the previous cycle. The vector select is 2'b00 whenever no change pulse is present.
- R11: The mode output never shows 2'b11. If the state ever held that code, it would behave as fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| svc_i | input | 1 | Supervisor-call strobe |
| exc_i | input | 1 | Exception strobe |
| eret_i | input | 1 | Exception-return strobe |
| mode_o | output | 2 | Current mode: 00 user, 01 system, 10 fault |
| mode_chg_o | output | 1 | One-cycle pulse on a mode transition |
| vec_sel_o | output | 2 | Handler vector: 00 none, 01 call, 10 exception, 11 double fault |
| save_pc_o | output | 1 | Pulse telling the banked file to save the program counter |
| restore_pc_o | output | 1 | Pulse telling the banked file to restore the program counter |
| halt_o | output | 1 | Sticky halt request raised from fault mode |

## Verification
A wrong mode register shows at mode_o on the first edge after the faulty transition. It also shows in the following cycle, because the next request is then handled under the wrong rules: for example, an exception return that should go to user mode is ignored. A missing or extra change, save or restore pulse can be seen only in the cycle right after the request, so every request is checked in exactly that cycle. A halt flag that is lost or set too early shows on the next idle cycle in fault mode, because halt must then stay high.

// File: rtl/priv_mode_pkg.sv
package priv_mode_pkg;
  localparam int MODE_W = 2;
  localparam int VEC_W  = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_USER  = 2'b00,
    MODE_SYS   = 2'b01,
    MODE_FAULT = 2'b10
  } priv_mode_e;

  typedef enum logic [VEC_W-1:0] {
    VEC_NONE = 2'b00,
    VEC_SVC  = 2'b01,
    VEC_EXC  = 2'b10,
    VEC_DBL  = 2'b11
  } vec_sel_e;

  typedef struct packed {
    logic [MODE_W-1:0] mode;
    logic              chg;
    logic [VEC_W-1:0]  vec;
    logic              save;
    logic              restore;
    logic              halt_set;
  } trans_t;
endpackage

// File: rtl/priv_rst_sync.sv
module priv_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= 1'b1;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/priv_mode_next.sv
module priv_mode_next
  import priv_mode_pkg::*;
(
  input  logic [MODE_W-1:0] cur_mode,
  input  logic              svc,
  input  logic              exc,
  input  logic              eret,
  output trans_t            nxt
);
  always_comb begin
    nxt          = '0;
    nxt.mode     = cur_mode;
    nxt.vec      = VEC_NONE;
    case (cur_mode)
      MODE_USER: begin
        if (exc) begin
          nxt.mode = MODE_SYS;
          nxt.vec  = VEC_EXC;
          nxt.save = 1'b1;
        end else if (svc) begin
          nxt.mode = MODE_SYS;
          nxt.vec  = VEC_SVC;
          nxt.save = 1'b1;
        end
      end
      MODE_SYS: begin
        if (exc) begin
          nxt.mode = MODE_FAULT;
          nxt.vec  = VEC_DBL;
          nxt.save = 1'b1;
        end else if (eret) begin
          nxt.mode    = MODE_USER;
          nxt.restore = 1'b1;
        end
      end
      default: begin
        nxt.mode     = MODE_FAULT;
        nxt.halt_set = svc | exc | eret;
      end
    endcase
    nxt.chg = (nxt.mode != cur_mode);
  end
endmodule

// File: rtl/priv_mode_regs.sv
module priv_mode_regs
  import priv_mode_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  trans_t            nxt,
  output logic [MODE_W-1:0] mode_q,
  output logic              chg_q,
  output logic [VEC_W-1:0]  vec_q,
  output logic              save_q,
  output logic              restore_q,
  output logic              halt_q
);
  logic mode_en;
  logic halt_en;

  assign mode_en = nxt.chg;
  assign halt_en = nxt.halt_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= MODE_SYS;
    else if (mode_en) mode_q <= nxt.mode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       halt_q <= 1'b0;
    else if (halt_en) halt_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chg_q     <= 1'b0;
      vec_q     <= VEC_NONE;
      save_q    <= 1'b0;
      restore_q <= 1'b0;
    end else begin
      chg_q     <= nxt.chg;
      vec_q     <= nxt.vec;
      save_q    <= nxt.save;
      restore_q <= nxt.restore;
    end
  end
endmodule

// File: rtl/priv_mode_ctrl.sv
module priv_mode_ctrl
  import priv_mode_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              svc_i,
  input  logic              exc_i,
  input  logic              eret_i,
  output logic [MODE_W-1:0] mode_o,
  output logic              mode_chg_o,
  output logic [VEC_W-1:0]  vec_sel_o,
  output logic              save_pc_o,
  output logic              restore_pc_o,
  output logic              halt_o
);
  logic   rst_sync_n;
  trans_t nxt;

  priv_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  priv_mode_next u_next (
    .cur_mode (mode_o),
    .svc      (svc_i),
    .exc      (exc_i),
    .eret     (eret_i),
    .nxt      (nxt)
  );

  priv_mode_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .nxt       (nxt),
    .mode_q    (mode_o),
    .chg_q     (mode_chg_o),
    .vec_q     (vec_sel_o),
    .save_q    (save_pc_o),
    .restore_q (restore_pc_o),
    .halt_q    (halt_o)
  );
endmodule

// File: rtl/priv_mode_chk.sv
module priv_mode_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       svc,
  input logic       exc,
  input logic       eret,
  input logic [1:0] mode,
  input logic       chg,
  input logic [1:0] vec,
  input logic       save,
  input logic       restore,
  input logic       halt
);
  assert_user_svc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && svc && !exc) |=> (mode == 2'b01 && vec == 2'b01 && save));

  assert_user_exc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && exc) |=> (mode == 2'b01 && vec == 2'b10 && save));

  assert_double_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && exc) |=> (mode == 2'b10 && vec == 2'b11 && save));

  assert_return_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && eret && !exc) |=> (mode == 2'b00 && restore && !save));

  assert_fault_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10) |=> (mode == 2'b10 && !chg));

  assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> halt);

  assert_chg_on_move_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode) |-> chg);

  assert_chg_only_move_R10: assert property (@(posedge clk) disable iff (!rst_n)
    chg |-> !$stable(mode));

  assert_vec_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !chg |-> (vec == 2'b00));

  assert_no_illegal_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'b11);
endmodule

bind priv_mode_ctrl priv_mode_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .svc     (svc_i),
  .exc     (exc_i),
  .eret    (eret_i),
  .mode    (mode_o),
  .chg     (mode_chg_o),
  .vec     (vec_sel_o),
  .save    (save_pc_o),
  .restore (restore_pc_o),
  .halt    (halt_o)
);

// File: tb/tb_priv_mode_ctrl.sv
module tb_priv_mode_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       svc_i = 1'b0;
  logic       exc_i = 1'b0;
  logic       eret_i = 1'b0;
  logic [1:0] mode_o;
  logic       mode_chg_o;
  logic [1:0] vec_sel_o;
  logic       save_pc_o;
  logic       restore_pc_o;
  logic       halt_o;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  priv_mode_ctrl dut (
    .clk(clk), .rst_n(rst_n), .svc_i(svc_i), .exc_i(exc_i), .eret_i(eret_i),
    .mode_o(mode_o), .mode_chg_o(mode_chg_o), .vec_sel_o(vec_sel_o),
    .save_pc_o(save_pc_o), .restore_pc_o(restore_pc_o), .halt_o(halt_o)
  );

  // stimulus {svc,exc,eret} and expected {mode,chg,vec,save,restore,halt}
  localparam int NV = 14;
  localparam logic [10:0] VECS [NV] = '{
    {3'b000, 2'b01, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0}, // R1 idle in system
    {3'b100, 2'b01, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0}, // R8 call in system ignored
    {3'b001, 2'b00, 1'b1, 2'b00, 1'b0, 1'b1, 1'b0}, // R6 return to user
    {3'b001, 2'b00, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0}, // R8 return in user ignored
    {3'b100, 2'b01, 1'b1, 2'b01, 1'b1, 1'b0, 1'b0}, // R2 call
    {3'b001, 2'b00, 1'b1, 2'b00, 1'b0, 1'b1, 1'b0}, // R6
    {3'b010, 2'b01, 1'b1, 2'b10, 1'b1, 1'b0, 1'b0}, // R3 exception
    {3'b001, 2'b00, 1'b1, 2'b00, 1'b0, 1'b1, 1'b0}, // R6
    {3'b110, 2'b01, 1'b1, 2'b10, 1'b1, 1'b0, 1'b0}, // R4 exception beats call
    {3'b011, 2'b10, 1'b1, 2'b11, 1'b1, 1'b0, 1'b0}, // R7 R5 double fault
    {3'b000, 2'b10, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0}, // R10 no pulse, no halt yet
    {3'b001, 2'b10, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1}, // R9 return ignored, halt
    {3'b000, 2'b10, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1}, // R9 halt sticky
    {3'b010, 2'b10, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1}  // R9 exception ignored
  };

  task automatic check(input string req, input logic [7:0] exp);
    logic [7:0] act;
    act = {mode_o, mode_chg_o, vec_sel_o, save_pc_o, restore_pc_o, halt_o};
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: {mode,chg,vec,save,restore,halt} actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic apply(input logic [2:0] stim);
    {svc_i, exc_i, eret_i} = stim;
    @(negedge clk);
    {svc_i, exc_i, eret_i} = 3'b000;
  endtask

  task automatic release_reset();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", {2'b01, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0});
    release_reset();
    check("R1 after release", {2'b01, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0});

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i][10:8]);
      check($sformatf("vector %0d (R2..R10)", i), VECS[i][7:0]);
    end

    // reset from fault mode clears halt (R1)
    #1 rst_n = 1'b0;
    #1 check("R1 async reset from fault", {2'b01, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0});
    release_reset();
    check("R1 halt cleared", {2'b01, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0});

    // lone exception in system mode (R5)
    apply(3'b010);
    check("R5 double fault", {2'b10, 1'b1, 2'b11, 1'b1, 1'b0, 1'b0});
    apply(3'b000);
    check("R10 pulse ends", {2'b10, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0});
    apply(3'b100);
    check("R9 call in fault sets halt", {2'b10, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1});
    apply(3'b000);
    check("R11 mode stays legal", {2'b10, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1});

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
    end
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule